// File: doc/BRIEF.md
# Colour Lookup Table Port Interface

This block holds a 256-entry colour table. Each entry has three 6-bit components: red, green and blue. A processor reaches the table through byte-wide ports on one shared bus. The port is chosen by a 3-bit select code.

One port sets the entry where writes begin. A second port sets the entry where reads begin. A single data port moves the colour values, three accesses per entry in red, green, blue order. When the third access completes, the entry address steps forward by one, so the whole table can be streamed in one run. A mask port holds a pixel mask that can be written and read back. A state port reports whether the last address loaded was a read address or a write address.

On the display side, an 8-bit pixel index is ANDed with the mask. The result selects an entry, and the block returns that entry as one 18-bit colour word.

Control is a small state machine built from two state variables.

The transfer mode has two states:
- `MODE_WRITE` is the state after reset.
- A write to the read-address port moves it to `MODE_READ`.
- A write to the write-address port moves it back to `MODE_WRITE`.

The component counter steps through `COMP_R`, `COMP_G`, `COMP_B` and returns to `COMP_R`:
- Each data-port access moves it one step.
- The step from `COMP_B` to `COMP_R` also advances the entry address.
- A write to either address port forces the counter to `COMP_R`.

Top module: `clut_dac`

## Requirements
- R1: Writing port code 0 (write address) loads the write pointer, returns the component counter to red and selects write mode. Reading port code 0 returns the current write pointer.
- R2: Writing port code 1 (read address) loads the read pointer, returns the component counter to red and selects read mode.
- R3: Writes to port code 2 (data) are taken as red, green, blue. The entry at the write pointer keeps its old value until the blue byte arrives, and then all three components are replaced together.
- R4: After the blue component is written or read, the pointer in use advances by one, wrapping from 255 to 0.
- R5: Only bits 5:0 of a written data byte are stored. A data read returns red, green, then blue of the entry at the read pointer, with bits 7:6 zero.
- R6: Reading port code 4 (state) returns 0x00 in write mode and 0x03 in read mode.
- R7: Port code 3 (mask) is written and read back as a full byte, and resets to 0xFF.
- R8: `pix_rgb` shows, one cycle after `pix_idx` is applied, the entry selected by `pix_idx & mask`. The word is packed as red in bits 17:12, green in bits 11:6 and blue in bits 5:0.
- R9: A pixel lookup in the same cycle as a blue write to the same entry returns the old colour. The new colour appears on the next lookup cycle.
- R10: After reset, `bus_rdata` is 0x00, both pointers are 0, the mode is write and `pix_rgb` is 0.
- R11: `bus_rdata` updates one cycle after a read strobe and otherwise holds its value. When `bus_wr` and `bus_rd` are high together, only the write is performed. Writes to port codes 5 to 7 are ignored, and reads of port codes 1 and 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Port code for the access |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_rgb | output | 18 | Registered colour of the selected entry |

## Verification
Two functions can fall in the same cycle: the blue-byte write that commits an entry, and the display lookup of that same entry. The bench sets up this collision by applying the blue strobe and the matching `pix_idx` on the same falling edge. It then expects the old colour after the shared rising edge and the new colour one cycle later. A second collision, simultaneous read and write strobes on the mask port, is judged by checking that `bus_rdata` keeps its earlier value while the mask still takes the new byte.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [2:0] {
        PORT_WADDR = 3'd0,
        PORT_RADDR = 3'd1,
        PORT_DATA  = 3'd2,
        PORT_MASK  = 3'd3,
        PORT_STATE = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } mode_e;

    localparam logic [7:0] STATE_CODE_WR = 8'h00;
    localparam logic [7:0] STATE_CODE_RD = 8'h03;

endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
    import clut_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 8,
    parameter int COMP_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            sel,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [BUS_W-1:0]      wdata,
    output logic [BUS_W-1:0]      rdata,
    input  logic [3*COMP_W-1:0]   rd_entry,
    output logic [ADDR_W-1:0]     rd_ptr,
    output logic                  commit_en,
    output logic [ADDR_W-1:0]     commit_addr,
    output logic [3*COMP_W-1:0]   commit_rgb,
    output logic [ADDR_W-1:0]     mask
);
    localparam int RGB_W = 3 * COMP_W;

    mode_e              mode_q, mode_d;
    comp_e              comp_q, comp_d;
    logic [ADDR_W-1:0]  wr_ptr_q, wr_ptr_d;
    logic [ADDR_W-1:0]  rd_ptr_q, rd_ptr_d;
    logic [COMP_W-1:0]  hold_r_q, hold_r_d;
    logic [COMP_W-1:0]  hold_g_q, hold_g_d;
    logic [ADDR_W-1:0]  mask_q, mask_d;
    logic [BUS_W-1:0]   rdata_q, rdata_d;
    logic [COMP_W-1:0]  comp_val;
    logic               do_rd;

    // a write strobe wins over a simultaneous read strobe
    assign do_rd = rd_en & ~wr_en;

    always_comb begin
        unique case (comp_q)
            COMP_R:  comp_val = rd_entry[RGB_W-1 -: COMP_W];
            COMP_G:  comp_val = rd_entry[2*COMP_W-1 -: COMP_W];
            default: comp_val = rd_entry[COMP_W-1:0];
        endcase
    end

    // next-state logic
    always_comb begin
        mode_d    = mode_q;
        comp_d    = comp_q;
        wr_ptr_d  = wr_ptr_q;
        rd_ptr_d  = rd_ptr_q;
        hold_r_d  = hold_r_q;
        hold_g_d  = hold_g_q;
        mask_d    = mask_q;
        rdata_d   = rdata_q;
        commit_en = 1'b0;
        if (wr_en) begin
            unique case (sel)
                PORT_WADDR: begin
                    wr_ptr_d = wdata[ADDR_W-1:0];
                    comp_d   = COMP_R;
                    mode_d   = MODE_WRITE;
                end
                PORT_RADDR: begin
                    rd_ptr_d = wdata[ADDR_W-1:0];
                    comp_d   = COMP_R;
                    mode_d   = MODE_READ;
                end
                PORT_DATA: begin
                    unique case (comp_q)
                        COMP_R: begin
                            hold_r_d = wdata[COMP_W-1:0];
                            comp_d   = COMP_G;
                        end
                        COMP_G: begin
                            hold_g_d = wdata[COMP_W-1:0];
                            comp_d   = COMP_B;
                        end
                        default: begin
                            commit_en = 1'b1;
                            wr_ptr_d  = wr_ptr_q + ADDR_W'(1);
                            comp_d    = COMP_R;
                        end
                    endcase
                end
                PORT_MASK: mask_d = wdata[ADDR_W-1:0];
                default: ;
            endcase
        end else if (do_rd) begin
            unique case (sel)
                PORT_WADDR: rdata_d = BUS_W'(wr_ptr_q);
                PORT_DATA: begin
                    rdata_d = BUS_W'(comp_val);
                    unique case (comp_q)
                        COMP_R: comp_d = COMP_G;
                        COMP_G: comp_d = COMP_B;
                        default: begin
                            comp_d   = COMP_R;
                            rd_ptr_d = rd_ptr_q + ADDR_W'(1);
                        end
                    endcase
                end
                PORT_MASK:  rdata_d = BUS_W'(mask_q);
                PORT_STATE: rdata_d = (mode_q == MODE_READ) ? BUS_W'(STATE_CODE_RD)
                                                            : BUS_W'(STATE_CODE_WR);
                default:    rdata_d = '0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_WRITE;
            comp_q   <= COMP_R;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            hold_r_q <= '0;
            hold_g_q <= '0;
            mask_q   <= '1;
            rdata_q  <= '0;
        end else begin
            mode_q   <= mode_d;
            comp_q   <= comp_d;
            wr_ptr_q <= wr_ptr_d;
            rd_ptr_q <= rd_ptr_d;
            hold_r_q <= hold_r_d;
            hold_g_q <= hold_g_d;
            mask_q   <= mask_d;
            rdata_q  <= rdata_d;
        end
    end

    // outputs
    assign rdata       = rdata_q;
    assign rd_ptr      = rd_ptr_q;
    assign mask        = mask_q;
    assign commit_addr = wr_ptr_q;
    assign commit_rgb  = {hold_r_q, hold_g_q, wdata[COMP_W-1:0]};

    AST_WADDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == PORT_WADDR) |=> (comp_q == COMP_R && mode_q == MODE_WRITE)); // R1
    AST_RADDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == PORT_RADDR) |=> (comp_q == COMP_R && mode_q == MODE_READ)); // R2
    AST_PTR_HOLD_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == PORT_DATA && comp_q != COMP_B) |=> $stable(wr_ptr_q)); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> (wr_ptr_q == $past(wr_ptr_q) + ADDR_W'(1))); // R4
    AST_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && sel == PORT_DATA) |=> (rdata_q[BUS_W-1:COMP_W] == '0)); // R5
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/clut_mem.sv
module clut_mem #(
    parameter int ADDR_W = 8,
    parameter int COMP_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [3*COMP_W-1:0]  wrgb,
    input  logic [ADDR_W-1:0]    raddr,
    output logic [3*COMP_W-1:0]  rrgb,
    input  logic [ADDR_W-1:0]    pix_idx,
    input  logic [ADDR_W-1:0]    mask,
    output logic [3*COMP_W-1:0]  pix_rgb
);
    localparam int ENTRIES = 1 << ADDR_W;
    localparam int RGB_W   = 3 * COMP_W;

    logic [RGB_W-1:0] tbl [ENTRIES];
    logic [RGB_W-1:0] pix_q;

    always_ff @(posedge clk) begin
        if (we) tbl[waddr] <= wrgb;
    end

    // lookup samples the table before a same-edge commit lands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= tbl[pix_idx & mask];
    end

    assign rrgb    = tbl[raddr];
    assign pix_rgb = pix_q;

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (tbl[$past(waddr)] == $past(wrgb))); // R3
endmodule

// File: rtl/clut_dac.sv
module clut_dac #(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 8,
    parameter int COMP_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           bus_sel,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [ADDR_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0]  pix_rgb
);
    localparam int RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0]  rd_entry;
    logic [ADDR_W-1:0] rd_ptr;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [RGB_W-1:0]  commit_rgb;
    logic [ADDR_W-1:0] mask;

    clut_ctrl #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .rd_entry   (rd_entry),
        .rd_ptr     (rd_ptr),
        .commit_en  (commit_en),
        .commit_addr(commit_addr),
        .commit_rgb (commit_rgb),
        .mask       (mask)
    );

    clut_mem #(.ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (commit_en),
        .waddr  (commit_addr),
        .wrgb   (commit_rgb),
        .raddr  (rd_ptr),
        .rrgb   (rd_entry),
        .pix_idx(pix_idx),
        .mask   (mask),
        .pix_rgb(pix_rgb)
    );
endmodule

// File: tb/clut_dac_bench.sv
`timescale 1ns/1ps
module clut_dac_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [17:0] pix_rgb;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    clut_dac u_clut_dac (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk); bus_sel = s; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic lookup(input logic [7:0] idx, output logic [17:0] c);
        @(negedge clk); pix_idx = idx;
        @(negedge clk); c = pix_rgb;
    endtask

    function automatic logic [17:0] pack(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        return {r[5:0], g[5:0], b[5:0]};
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        check("R10 rdata", 32'(bus_rdata), 32'h00);
        check("R10 pix_rgb", 32'(pix_rgb), 32'h0);
        brd(3'd0, v); check("R10 write pointer", 32'(v), 32'h00);
        brd(3'd4, v); check("R10 mode", 32'(v), 32'h00);
        brd(3'd3, v); check("R7 mask reset", 32'(v), 32'hFF);
    endtask

    task automatic t_triplet;
        logic [7:0] v;
        bwr(3'd0, 8'h00);
        bwr(3'd2, 8'hC1); bwr(3'd2, 8'h02); bwr(3'd2, 8'h83);
        bwr(3'd2, 8'h14); bwr(3'd2, 8'h25); bwr(3'd2, 8'h36);
        brd(3'd0, v); check("R1 R4 write pointer after two entries", 32'(v), 32'h02);
        brd(3'd4, v); check("R6 write mode", 32'(v), 32'h00);
        bwr(3'd1, 8'h00);
        brd(3'd4, v); check("R6 R2 read mode", 32'(v), 32'h03);
        brd(3'd2, v); check("R5 red truncated", 32'(v), 32'h01);
        brd(3'd2, v); check("R5 green", 32'(v), 32'h02);
        brd(3'd2, v); check("R5 blue truncated", 32'(v), 32'h03);
        brd(3'd2, v); check("R4 read advance red", 32'(v), 32'h14);
        brd(3'd2, v); check("R2 restart mid entry setup", 32'(v), 32'h25);
        bwr(3'd1, 8'h01);
        brd(3'd2, v); check("R2 counter back to red", 32'(v), 32'h14);
    endtask

    task automatic t_partial;
        logic [17:0] c;
        bwr(3'd0, 8'h07);
        bwr(3'd2, 8'h11); bwr(3'd2, 8'h22); bwr(3'd2, 8'h33);
        bwr(3'd0, 8'h07);
        bwr(3'd2, 8'h3F); bwr(3'd2, 8'h3E);
        lookup(8'h07, c); check("R3 entry unchanged before blue", 32'(c), 32'(pack(8'h11, 8'h22, 8'h33)));
        bwr(3'd2, 8'h01);
        lookup(8'h07, c); check("R3 R8 entry after blue", 32'(c), 32'(pack(8'h3F, 8'h3E, 8'h01)));
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        bwr(3'd0, 8'hFF);
        bwr(3'd2, 8'h0A); bwr(3'd2, 8'h0B); bwr(3'd2, 8'h0C);
        brd(3'd0, v); check("R4 write wrap", 32'(v), 32'h00);
        bwr(3'd2, 8'h2A); bwr(3'd2, 8'h2B); bwr(3'd2, 8'h2C);
        bwr(3'd1, 8'hFF);
        brd(3'd2, v); brd(3'd2, v); brd(3'd2, v); check("R5 entry 255 blue", 32'(v), 32'h0C);
        brd(3'd2, v); check("R4 read wrap to entry 0", 32'(v), 32'h2A);
    endtask

    task automatic t_mask;
        logic [7:0] v;
        logic [17:0] c;
        bwr(3'd3, 8'h0F);
        brd(3'd3, v); check("R7 mask readback", 32'(v), 32'h0F);
        lookup(8'hF7, c); check("R8 masked index", 32'(c), 32'(pack(8'h3F, 8'h3E, 8'h01)));
        bwr(3'd3, 8'hFF);
        lookup(8'hFF, c); check("R8 full mask", 32'(c), 32'(pack(8'h0A, 8'h0B, 8'h0C)));
    endtask

    task automatic t_collide;
        logic [17:0] c;
        bwr(3'd0, 8'h07);
        bwr(3'd2, 8'h05); bwr(3'd2, 8'h06);
        @(negedge clk); bus_sel = 3'd2; bus_wdata = 8'h07; bus_wr = 1'b1; pix_idx = 8'h07;
        @(negedge clk); bus_wr = 1'b0;
        check("R9 old colour on collision", 32'(pix_rgb), 32'(pack(8'h3F, 8'h3E, 8'h01)));
        @(negedge clk);
        check("R9 new colour next cycle", 32'(pix_rgb), 32'(pack(8'h05, 8'h06, 8'h07)));
        c = pix_rgb;
    endtask

    task automatic t_both;
        logic [7:0] v;
        brd(3'd3, v);
        @(negedge clk); bus_sel = 3'd3; bus_wdata = 8'h3C; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
        check("R11 read ignored when both", 32'(bus_rdata), 32'hFF);
        brd(3'd3, v); check("R11 write taken when both", 32'(v), 32'h3C);
        bwr(3'd3, 8'hFF);
        bwr(3'd0, 8'h40);
        bwr(3'd6, 8'h12);
        brd(3'd0, v); check("R11 unused write ignored", 32'(v), 32'h40);
        brd(3'd6, v); check("R11 unused read zero", 32'(v), 32'h00);
        brd(3'd1, v); check("R11 read-address port reads zero", 32'(v), 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_triplet();
        t_partial();
        t_wrap();
        t_mask();
        t_collide();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule